// File: doc/BRIEF.md
# Data Access Relocation, Alignment and Breakpoint Checker

This block screens each data memory access before it reaches the memory system. On an access strobe it captures the raw address and the load/store direction, along with the live contents of five control registers: the process identifier, the system control word, the two breakpoint words and the breakpoint control word. It also captures the debug status word. During the following cycle it presents the address with the process identifier folded in, an alignment abort together with the fault status and fault address values to be logged, and a breakpoint hit.

The top of the address, bits 31:25 with the default parameters, is a relocation field. A small address whose field is empty is moved into the current process's slot, and every later check sees the moved address. The two breakpoint comparators work in one of two modes. In the first they are independent word-address matches. In the second they combine into one base address plus an inverse mask that covers a range. Each comparator carries a direction filter. Abort vectoring and the debug handler sit outside the block; they consume its outputs.

Top module: `dacc_checker_top`

## Requirements
- R1: While reset is held and in the first cycle after it, all outputs are zero: the relocated address, the abort, the fault status, the fault address and the hit.
- R2: The block samples an access on the rising edge where `accValid` is high, and its outputs describe that access for the next cycle only. If `accValid` is then low, `alignAbort` and `bkptHit` return to zero in the cycle after that.
- R3: When `pidReg[31:25]` is nonzero and `accAddr[31:25]` is zero, `relocAddr` is `{pidReg[31:25], accAddr[24:0]}`. The low 25 bits of `pidReg` have no effect.
- R4: When `pidReg[31:25]` is zero or `accAddr[31:25]` is nonzero, `relocAddr` equals `accAddr`.
- R5: When `ctrlReg[1]` is set and `relocAddr[1:0]` is nonzero, `alignAbort` is high, `faultStatus` is 32'h0000_0400 and `faultAddr` is the relocated address. In any cycle without an abort, both `faultStatus` and `faultAddr` are zero.
- R6: When `ctrlReg[1]` is clear, a misaligned address raises no abort.
- R7: Each comparator has a 2-bit direction field: `bkptCtrl[1:0]` for comparator 0 and `bkptCtrl[3:2]` for comparator 1. The codes are 0 = off, 1 = stores only, 2 = loads and stores, 3 = loads only.
- R8: When `bkptCtrl[8]` is clear, comparator 0 hits when `relocAddr[31:2]` equals `bkptAddr0[31:2]`, and comparator 1 does the same against `bkptAddr1`. Address bits 1:0 are ignored, and a hit from either comparator raises `bkptHit`.
- R9: When `bkptCtrl[8]` is set, a hit needs `(relocAddr & ~bkptAddr1) == (bkptAddr0 & ~bkptAddr1)` and a direction allowed by `bkptCtrl[1:0]`. The field `bkptCtrl[3:2]` has no effect in this mode.
- R10: When `dbgCtrl[31]` is set, `bkptHit` stays low, but alignment aborts still occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access strobe; inputs are sampled on this edge |
| accAddr | input | 32 | Raw data address |
| accStore | input | 1 | 1 = store, 0 = load |
| pidReg | input | 32 | Process identifier register contents |
| ctrlReg | input | 32 | System control register contents (bit 1 = alignment check) |
| bkptAddr0 | input | 32 | Breakpoint word 0 (base in range mode) |
| bkptAddr1 | input | 32 | Breakpoint word 1 (inverse mask in range mode) |
| bkptCtrl | input | 32 | Breakpoint control (direction fields, mode select) |
| dbgCtrl | input | 32 | Debug status word (bit 31 suppresses breakpoints) |
| relocAddr | output | 32 | Address after process relocation |
| alignAbort | output | 1 | Data abort for a misaligned access |
| faultStatus | output | 32 | Fault status value to log on an abort |
| faultAddr | output | 32 | Fault address value to log on an abort |
| bkptHit | output | 1 | Data breakpoint matched |

## Verification
Relocation is tried four ways: an empty address field with a filled identifier, the same identifier carrying junk in its low bits, a filled address field, and an empty identifier. Together these separate the move from a plain OR and from a pass-through. Alignment is driven with each low-bit pattern under enable on and enable off, and once through a relocated address, which shows whether the fault address is taken before or after the move. The breakpoint tests step every direction code through both a load and a store. Near-miss addresses distinguish a byte compare from a word compare and comparator 0 from comparator 1. In range mode, an address that would match word 1 but not the range shows that the mask is read as inverted and that the second field is ignored.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // load the access stage
    logic abort;    // current access raises an alignment abort
  } ctlStrobe_t;

  // Raw conditions reported by the datapath.
  typedef struct packed {
    logic       misaligned;
    logic       alignEn;
    logic       isStore;
    logic       haltDbg;
    logic       maskMode;
    logic [1:0] dir0;
    logic [1:0] dir1;
    logic       wordHit0;
    logic       wordHit1;
    logic       rangeHit;
  } dpStatus_t;

  // Direction filter: 0 off, 1 stores, 2 both, 3 loads.
  function automatic logic dirAllows(input logic [1:0] dir, input logic isStore);
    case (dir)
      2'd0:    return 1'b0;
      2'd1:    return isStore;
      2'd2:    return 1'b1;
      default: return ~isStore;
    endcase
  endfunction

endpackage

// File: rtl/dacc_datapath.sv
module dacc_datapath
  import dacc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PID_W     = 7,
  parameter int ALIGN_BIT = 1,
  parameter int MASK_BIT  = 8,
  parameter int HALT_BIT  = 31,
  parameter logic [ADDR_W-1:0] FAULT_CODE = 'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accStore,
  input  logic [ADDR_W-1:0] pidReg,
  input  logic [ADDR_W-1:0] ctrlReg,
  input  logic [ADDR_W-1:0] bkptAddr0,
  input  logic [ADDR_W-1:0] bkptAddr1,
  input  logic [ADDR_W-1:0] bkptCtrl,
  input  logic [ADDR_W-1:0] dbgCtrl,
  output dpStatus_t         status,
  output logic [ADDR_W-1:0] relocAddr,
  output logic [ADDR_W-1:0] faultStatus,
  output logic [ADDR_W-1:0] faultAddr
);

  localparam int RELOC_LO = ADDR_W - PID_W;
  localparam int WORD_LSB = 2;
  localparam int NUM_CMP  = 2;

  logic [ADDR_W-1:0]              addrQ;
  logic                           storeQ;
  logic [PID_W-1:0]               pidQ;
  logic                           alignEnQ;
  logic [NUM_CMP-1:0][ADDR_W-1:0] bkptQ;
  logic [2*NUM_CMP-1:0]           dirQ;
  logic                           maskQ;
  logic                           haltQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      storeQ   <= 1'b0;
      pidQ     <= '0;
      alignEnQ <= 1'b0;
      bkptQ    <= '0;
      dirQ     <= '0;
      maskQ    <= 1'b0;
      haltQ    <= 1'b0;
    end else if (strobe.capture) begin
      addrQ    <= accAddr;
      storeQ   <= accStore;
      pidQ     <= pidReg[ADDR_W-1:RELOC_LO];
      alignEnQ <= ctrlReg[ALIGN_BIT];
      bkptQ    <= {bkptAddr1, bkptAddr0};
      dirQ     <= bkptCtrl[2*NUM_CMP-1:0];
      maskQ    <= bkptCtrl[MASK_BIT];
      haltQ    <= dbgCtrl[HALT_BIT];
    end
  end

  // Register bits this block does not decode.
  logic unusedBits;
  assign unusedBits = ^{pidReg[RELOC_LO-1:0], ctrlReg, bkptCtrl, dbgCtrl};

  // Process relocation.
  logic moveAddr;
  assign moveAddr  = (pidQ != '0) && (addrQ[ADDR_W-1:RELOC_LO] == '0);
  assign relocAddr = moveAddr ? {pidQ, addrQ[RELOC_LO-1:0]} : addrQ;

  // Word comparators.
  logic [NUM_CMP-1:0] wordHit;
  for (genvar i = 0; i < NUM_CMP; i++) begin : gCmp
    assign wordHit[i] = relocAddr[ADDR_W-1:WORD_LSB] == bkptQ[i][ADDR_W-1:WORD_LSB];
  end

  // Range comparator: word 1 is an inverse mask over word 0.
  logic rangeHit;
  assign rangeHit = ((relocAddr ^ bkptQ[0]) & ~bkptQ[1]) == '0;

  always_comb begin
    status.misaligned = relocAddr[WORD_LSB-1:0] != '0;
    status.alignEn    = alignEnQ;
    status.isStore    = storeQ;
    status.haltDbg    = haltQ;
    status.maskMode   = maskQ;
    status.dir0       = dirQ[1:0];
    status.dir1       = dirQ[3:2];
    status.wordHit0   = wordHit[0];
    status.wordHit1   = wordHit[1];
    status.rangeHit   = rangeHit;
  end

  assign faultStatus = strobe.abort ? FAULT_CODE : '0;
  assign faultAddr   = strobe.abort ? relocAddr  : '0;

endmodule

// File: rtl/dacc_control.sv
module dacc_control
  import dacc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       accValid,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       alignAbort,
  output logic       bkptHit
);

  logic validQ;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= accValid;
  end

  logic hit0, hit1, rangeOk, anyHit;

  assign hit0    = status.wordHit0 & dirAllows(status.dir0, status.isStore);
  assign hit1    = status.wordHit1 & dirAllows(status.dir1, status.isStore);
  assign rangeOk = status.rangeHit & dirAllows(status.dir0, status.isStore);
  assign anyHit  = status.maskMode ? rangeOk : (hit0 | hit1);

  assign strobe.capture = accValid;
  assign strobe.abort   = validQ & status.alignEn & status.misaligned;
  assign alignAbort     = strobe.abort;
  assign bkptHit        = validQ & ~status.haltDbg & anyHit;

endmodule

// File: rtl/dacc_checker_top.sv
module dacc_checker_top
  import dacc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PID_W     = 7,
  parameter int ALIGN_BIT = 1,
  parameter int MASK_BIT  = 8,
  parameter int HALT_BIT  = 31,
  parameter logic [ADDR_W-1:0] FAULT_CODE = 'h400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accStore,
  input  logic [ADDR_W-1:0] pidReg,
  input  logic [ADDR_W-1:0] ctrlReg,
  input  logic [ADDR_W-1:0] bkptAddr0,
  input  logic [ADDR_W-1:0] bkptAddr1,
  input  logic [ADDR_W-1:0] bkptCtrl,
  input  logic [ADDR_W-1:0] dbgCtrl,
  output logic [ADDR_W-1:0] relocAddr,
  output logic              alignAbort,
  output logic [ADDR_W-1:0] faultStatus,
  output logic [ADDR_W-1:0] faultAddr,
  output logic              bkptHit
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  dacc_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .accValid   (accValid),
    .status     (status),
    .strobe     (strobe),
    .alignAbort (alignAbort),
    .bkptHit    (bkptHit)
  );

  dacc_datapath #(
    .ADDR_W     (ADDR_W),
    .PID_W      (PID_W),
    .ALIGN_BIT  (ALIGN_BIT),
    .MASK_BIT   (MASK_BIT),
    .HALT_BIT   (HALT_BIT),
    .FAULT_CODE (FAULT_CODE)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .accAddr     (accAddr),
    .accStore    (accStore),
    .pidReg      (pidReg),
    .ctrlReg     (ctrlReg),
    .bkptAddr0   (bkptAddr0),
    .bkptAddr1   (bkptAddr1),
    .bkptCtrl    (bkptCtrl),
    .dbgCtrl     (dbgCtrl),
    .status      (status),
    .relocAddr   (relocAddr),
    .faultStatus (faultStatus),
    .faultAddr   (faultAddr)
  );

endmodule

// File: rtl/dacc_sva.sv
module dacc_sva #(
  parameter int ADDR_W    = 32,
  parameter int PID_W     = 7,
  parameter int ALIGN_BIT = 1,
  parameter int HALT_BIT  = 31
) (
  input logic              clk,
  input logic              rstN,
  input logic              accValid,
  input logic [ADDR_W-1:0] accAddr,
  input logic [ADDR_W-1:0] pidReg,
  input logic [ADDR_W-1:0] ctrlReg,
  input logic [ADDR_W-1:0] bkptCtrl,
  input logic [ADDR_W-1:0] dbgCtrl,
  input logic [ADDR_W-1:0] relocAddr,
  input logic              alignAbort,
  input logic [ADDR_W-1:0] faultStatus,
  input logic [ADDR_W-1:0] faultAddr,
  input logic              bkptHit
);

  localparam int RELOC_LO = ADDR_W - PID_W;

  assert_hit_sampled_R2: assert property (@(posedge clk) disable iff (!rstN)
    bkptHit |-> $past(accValid));

  assert_abort_sampled_R2: assert property (@(posedge clk) disable iff (!rstN)
    alignAbort |-> $past(accValid));

  assert_reloc_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(accValid) && $past(pidReg[ADDR_W-1:RELOC_LO]) != '0
      && $past(accAddr[ADDR_W-1:RELOC_LO]) == '0)
    |-> (relocAddr == {$past(pidReg[ADDR_W-1:RELOC_LO]), $past(accAddr[RELOC_LO-1:0])}));

  assert_fault_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    alignAbort |-> (faultAddr == relocAddr) && (faultAddr[1:0] != 2'b00));

  assert_quiet_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    !alignAbort |-> (faultStatus == '0) && (faultAddr == '0));

  assert_no_align_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(accValid) && !$past(ctrlReg[ALIGN_BIT])) |-> !alignAbort);

  assert_off_dir_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(accValid) && $past(bkptCtrl[3:0]) == 4'd0) |-> !bkptHit);

  assert_halt_R10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(accValid) && $past(dbgCtrl[HALT_BIT])) |-> !bkptHit);

endmodule

bind dacc_checker_top dacc_sva #(
  .ADDR_W    (ADDR_W),
  .PID_W     (PID_W),
  .ALIGN_BIT (ALIGN_BIT),
  .HALT_BIT  (HALT_BIT)
) i_dacc_sva (
  .clk         (clk),
  .rstN        (rstN),
  .accValid    (accValid),
  .accAddr     (accAddr),
  .pidReg      (pidReg),
  .ctrlReg     (ctrlReg),
  .bkptCtrl    (bkptCtrl),
  .dbgCtrl     (dbgCtrl),
  .relocAddr   (relocAddr),
  .alignAbort  (alignAbort),
  .faultStatus (faultStatus),
  .faultAddr   (faultAddr),
  .bkptHit     (bkptHit)
);

// File: tb/test_dacc_checker_top.sv
module test_dacc_checker_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] FSR_CODE = 32'h0000_0400;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accStore = 1'b0;
  logic [31:0] pidReg = '0;
  logic [31:0] ctrlReg = '0;
  logic [31:0] bkptAddr0 = '0;
  logic [31:0] bkptAddr1 = '0;
  logic [31:0] bkptCtrl = '0;
  logic [31:0] dbgCtrl = '0;
  logic [31:0] relocAddr;
  logic        alignAbort;
  logic [31:0] faultStatus;
  logic [31:0] faultAddr;
  logic        bkptHit;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacc_checker_top i_dacc_checker_top (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accStore(accStore), .pidReg(pidReg), .ctrlReg(ctrlReg),
    .bkptAddr0(bkptAddr0), .bkptAddr1(bkptAddr1), .bkptCtrl(bkptCtrl),
    .dbgCtrl(dbgCtrl), .relocAddr(relocAddr), .alignAbort(alignAbort),
    .faultStatus(faultStatus), .faultAddr(faultAddr), .bkptHit(bkptHit)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Present one access, check the cycle after, then check the pulse ends.
  task automatic runAccess(input string req, input logic [31:0] addr,
                           input logic isStore, input logic [31:0] expReloc,
                           input logic expAbort, input logic expHit);
    @(negedge clk);
    accAddr  = addr;
    accStore = isStore;
    accValid = 1'b1;
    @(negedge clk);
    accValid = 1'b0;
    check(req, "relocAddr", relocAddr, expReloc);
    check(req, "alignAbort", {31'd0, alignAbort}, {31'd0, expAbort});
    check(req, "faultStatus", faultStatus, expAbort ? FSR_CODE : 32'd0);
    check(req, "faultAddr", faultAddr, expAbort ? expReloc : 32'd0);
    check(req, "bkptHit", {31'd0, bkptHit}, {31'd0, expHit});
    @(negedge clk);
    check("R2", "abort after drop", {31'd0, alignAbort}, 32'd0);
    check("R2", "hit after drop", {31'd0, bkptHit}, 32'd0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "relocAddr in reset", relocAddr, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "relocAddr", relocAddr, 32'd0);
    check("R1", "alignAbort", {31'd0, alignAbort}, 32'd0);
    check("R1", "faultStatus", faultStatus, 32'd0);
    check("R1", "faultAddr", faultAddr, 32'd0);
    check("R1", "bkptHit", {31'd0, bkptHit}, 32'd0);
  endtask

  task automatic testTiming();
    // R2: nothing changes before the sampling edge.
    @(negedge clk);
    pidReg   = 32'h0A00_0000;
    accAddr  = 32'h0000_0040;
    accValid = 1'b0;
    @(negedge clk);
    check("R2", "unsampled addr", relocAddr, 32'd0);
    pidReg = '0;
  endtask

  task automatic testReloc();
    pidReg = 32'h0A00_0000;
    runAccess("R3", 32'h0000_1234, 1'b0, 32'h0A00_1234, 1'b0, 1'b0);
    pidReg = 32'h0A01_FFFF;
    runAccess("R3", 32'h0000_1234, 1'b0, 32'h0A00_1234, 1'b0, 1'b0);
    pidReg = 32'h0A00_0000;
    runAccess("R4", 32'h1000_0010, 1'b1, 32'h1000_0010, 1'b0, 1'b0);
    pidReg = 32'h0000_0000;
    runAccess("R4", 32'h0000_1234, 1'b0, 32'h0000_1234, 1'b0, 1'b0);
  endtask

  task automatic testAlign();
    ctrlReg = 32'h0000_0002;
    runAccess("R5", 32'h0000_1002, 1'b0, 32'h0000_1002, 1'b1, 1'b0);
    runAccess("R5", 32'h0000_1001, 1'b1, 32'h0000_1001, 1'b1, 1'b0);
    runAccess("R5", 32'h0000_1000, 1'b0, 32'h0000_1000, 1'b0, 1'b0);
    pidReg = 32'h0A00_0000;
    runAccess("R5", 32'h0000_0003, 1'b1, 32'h0A00_0003, 1'b1, 1'b0);
    pidReg  = '0;
    ctrlReg = 32'hFFFF_FFFD;
    runAccess("R6", 32'h0000_1001, 1'b0, 32'h0000_1001, 1'b0, 1'b0);
    ctrlReg = '0;
  endtask

  task automatic testWordBkpt();
    bkptAddr0 = 32'h0000_2000;
    bkptAddr1 = 32'h0000_3000;
    bkptCtrl  = 32'h0000_0002;
    runAccess("R8", 32'h0000_2003, 1'b0, 32'h0000_2003, 1'b0, 1'b1);
    runAccess("R8", 32'h0000_2004, 1'b0, 32'h0000_2004, 1'b0, 1'b0);
    runAccess("R8", 32'h0000_3000, 1'b0, 32'h0000_3000, 1'b0, 1'b0);
    bkptCtrl = 32'h0000_0001;
    runAccess("R7", 32'h0000_2000, 1'b1, 32'h0000_2000, 1'b0, 1'b1);
    runAccess("R7", 32'h0000_2000, 1'b0, 32'h0000_2000, 1'b0, 1'b0);
    bkptCtrl = 32'h0000_0003;
    runAccess("R7", 32'h0000_2000, 1'b0, 32'h0000_2000, 1'b0, 1'b1);
    runAccess("R7", 32'h0000_2000, 1'b1, 32'h0000_2000, 1'b0, 1'b0);
    bkptCtrl = 32'h0000_0000;
    runAccess("R7", 32'h0000_2000, 1'b1, 32'h0000_2000, 1'b0, 1'b0);
    bkptCtrl = 32'h0000_0008;
    runAccess("R8", 32'h0000_3002, 1'b1, 32'h0000_3002, 1'b0, 1'b1);
    runAccess("R8", 32'h0000_2000, 1'b1, 32'h0000_2000, 1'b0, 1'b0);
    bkptCtrl = 32'h0000_000C;
    runAccess("R7", 32'h0000_3000, 1'b1, 32'h0000_3000, 1'b0, 1'b0);
  endtask

  task automatic testRangeBkpt();
    bkptAddr0 = 32'h0000_4000;
    bkptAddr1 = 32'h0000_00FF;
    bkptCtrl  = 32'h0000_010A;
    runAccess("R9", 32'h0000_40AB, 1'b0, 32'h0000_40AB, 1'b0, 1'b1);
    runAccess("R9", 32'h0000_4100, 1'b0, 32'h0000_4100, 1'b0, 1'b0);
    runAccess("R9", 32'h0000_00FC, 1'b1, 32'h0000_00FC, 1'b0, 1'b0);
    bkptCtrl = 32'h0000_0108;
    runAccess("R9", 32'h0000_4000, 1'b1, 32'h0000_4000, 1'b0, 1'b0);
    bkptCtrl = 32'h0000_0101;
    runAccess("R9", 32'h0000_4010, 1'b0, 32'h0000_4010, 1'b0, 1'b0);
    runAccess("R9", 32'h0000_4010, 1'b1, 32'h0000_4010, 1'b0, 1'b1);
  endtask

  task automatic testHalt();
    bkptAddr0 = 32'h0000_2000;
    bkptCtrl  = 32'h0000_0002;
    dbgCtrl   = 32'h8000_0000;
    ctrlReg   = 32'h0000_0002;
    runAccess("R10", 32'h0000_2000, 1'b0, 32'h0000_2000, 1'b0, 1'b0);
    runAccess("R10", 32'h0000_2001, 1'b1, 32'h0000_2001, 1'b1, 1'b0);
    dbgCtrl = 32'h7FFF_FFFF;
    runAccess("R10", 32'h0000_2000, 1'b0, 32'h0000_2000, 1'b0, 1'b1);
    dbgCtrl = '0;
    ctrlReg = '0;
  endtask

  initial begin
    testReset();
    testTiming();
    testReloc();
    testAlign();
    testWordBkpt();
    testRangeBkpt();
    testHalt();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule